// File: doc/BRIEF.md
# Looping Audio DMA Channel Counter

This block is the address and count engine of one audio DMA channel that plays or records through a circular buffer in memory. It keeps a buffer base address, a frame register that pairs the current longword index with the buffer size in longwords, a sample register that pairs a running sample count with its reload value, and a two-bit count of bytes already moved past the last whole longword. The bus master that owns the memory port offers a grant of some number of bytes. The engine answers with one request: the byte address to use and a length that fits the grant, the rest of the buffer and the rest of the sample period.

When the bus master reports how many bytes it actually moved, the engine advances its index and byte remainder. In loop mode it wraps the index back to the start of the buffer. It then either reloads the sample count at the end of a period or shrinks it by what was moved. At the end of a period it pulses an interrupt-set output. If the pending flag held outside the block is still set at that moment, it also pulses a lost-interrupt output. Until that report arrives, no further grant is taken. The channel ignores grants while it is disabled or paused.

Top module: `audio_ring_dma_counter`

## Requirements
- R1: After reset, xferValid, busy, irqSet and lostIrq are 0, and frameCntOut, sampCntOut and leftoverOut read 0.
- R2: A frame register write loads the index from bits 31:16 and the size minus one from bits 15:0, and it clears the leftover. A sample register write loads the same 16-bit value into both the running half (bits 31:16 of sampCntOut) and the reload half (bits 15:0).
- R3: One cycle after an accepted grant, xferValid is high for exactly one cycle, and xferAddr equals base + index*4 + leftover.
- R4: xferLen is the smallest of three values. The first is the grant rounded down to a multiple of 2^shift, where shift = stereo + wide16. The second is (size - index + 1)*4 + leftover. The third is (running count + 1) << shift.
- R5: A grant is not accepted when size < index, or when the rounded grant is zero.
- R6: While chanEnable is 0 or chanPause is 1, a grant is not accepted and no state changes.
- R7: On completion of M bytes, the index grows by (M + leftover) >> 2 and leftover becomes (M + leftover) & 3. The new values are readable the cycle after doneValid.
- R8: When loopStop is 0 and the advanced index exceeds size, the index becomes 0. When loopStop is 1, the index keeps its value from before the transfer.
- R9: When M equals the remaining sample bytes, the running count is reloaded. Otherwise it becomes (remaining - M - 1) >> shift.
- R10: A period end with intEnable set pulses irqSet for one cycle, the cycle after doneValid. With intEnable clear, irqSet stays low.
- R11: A period end while intEnable and irqPending are both set also pulses lostIrq in the same cycle as irqSet.
- R12: From an accepted grant until doneValid, busy is high and further grants are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| frameAddrWe | input | 1 | Load buffer base address |
| frameAddrIn | input | 32 | Buffer base address |
| frameCntWe | input | 1 | Load frame register (clears leftover) |
| frameCntIn | input | 32 | {index, size minus one} |
| sampCntWe | input | 1 | Load both halves of the sample register |
| sampCntIn | input | 16 | Sample count value |
| chanEnable | input | 1 | Channel enabled |
| chanPause | input | 1 | Channel paused |
| loopStop | input | 1 | 0 = wrap index, 1 = keep index |
| stereo | input | 1 | Stereo format (adds 1 to shift) |
| wide16 | input | 1 | 16-bit format (adds 1 to shift) |
| intEnable | input | 1 | Interrupt enable for this channel |
| irqPending | input | 1 | Interrupt flag still pending outside |
| grantValid | input | 1 | Bus master offers a grant |
| grantBytes | input | 16 | Bytes offered |
| xferValid | output | 1 | One-cycle transfer request |
| xferAddr | output | 32 | Transfer byte address |
| xferLen | output | 16 | Transfer byte length |
| doneValid | input | 1 | Bus master reports completion |
| doneBytes | input | 16 | Bytes actually moved |
| busy | output | 1 | Request outstanding |
| irqSet | output | 1 | Period-end interrupt pulse |
| lostIrq | output | 1 | Period end with interrupt still pending |
| frameCntOut | output | 32 | {index, size minus one} |
| sampCntOut | output | 32 | {running count, reload} |
| leftoverOut | output | 2 | Bytes past last whole longword |

## Verification
A grant sampled at one clock edge shows its address and length, with xferValid, after that same edge. The bench therefore drives the grant on a falling edge and checks the request on the next falling edge. A completion report takes effect at the edge where doneValid is sampled. The counter readback and the irqSet and lostIrq pulses are checked on the falling edge right after that edge. For rejected grants, the bench checks that xferValid and busy stay low at that same falling edge and one cycle later. Every expected value is written into the vector table or worked out by hand from the requirement formulas.

// File: rtl/ringdma_pkg.sv
package ringdma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } seqState_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic latchReq;  // capture address/length/format of a new request
    logic commit;    // apply the completion to the counters
  } pathStrobe_t;

endpackage

// File: rtl/ringdma_ctrl.sv
module ringdma_ctrl
  import ringdma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        grantValid,
  input  logic        chanEnable,
  input  logic        chanPause,
  input  logic        canStart,
  input  logic        doneValid,
  input  logic        expiryNow,
  input  logic        intEnable,
  input  logic        irqPending,
  output pathStrobe_t strobe,
  output logic        xferValid,
  output logic        busy,
  output logic        irqSet,
  output logic        lostIrq
);

  seqState_t state, stateNext;

  always_comb begin
    strobe.latchReq = (state == ST_IDLE) && grantValid && chanEnable &&
                      !chanPause && canStart;
    strobe.commit   = (state == ST_WAIT) && doneValid;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (strobe.latchReq) stateNext = ST_REQ;
      ST_REQ:  stateNext = ST_WAIT;
      ST_WAIT: if (strobe.commit) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      irqSet  <= 1'b0;
      lostIrq <= 1'b0;
    end else begin
      state   <= stateNext;
      irqSet  <= strobe.commit && expiryNow && intEnable;
      lostIrq <= strobe.commit && expiryNow && intEnable && irqPending;
    end
  end

  assign xferValid = (state == ST_REQ);
  assign busy      = (state != ST_IDLE);

  // R3/R12: a request lasts one cycle only
  assert_single_req_R12: assert property (@(posedge clk) disable iff (!rstN)
    xferValid |=> !xferValid);

  // R6: idle channel that is disabled or paused raises no request
  assert_idle_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && (!chanEnable || chanPause)) |=> !xferValid);

  // R11: a lost interrupt always comes with the set pulse
  assert_lost_with_set_R11: assert property (@(posedge clk) disable iff (!rstN)
    lostIrq |-> irqSet);

  // R10: interrupt set is a single-cycle pulse
  assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    irqSet |=> !irqSet);

endmodule

// File: rtl/ringdma_path.sv
module ringdma_path
  import ringdma_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 16,
  parameter int GRANT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameAddrWe,
  input  logic [ADDR_W-1:0]  frameAddrIn,
  input  logic               frameCntWe,
  input  logic [2*IDX_W-1:0] frameCntIn,
  input  logic               sampCntWe,
  input  logic [IDX_W-1:0]   sampCntIn,
  input  logic               stereo,
  input  logic               wide16,
  input  logic               loopStop,
  input  logic [GRANT_W-1:0] grantBytes,
  input  logic [GRANT_W-1:0] doneBytes,
  input  pathStrobe_t        strobe,
  output logic               canStart,
  output logic               expiryNow,
  output logic [ADDR_W-1:0]  xferAddr,
  output logic [GRANT_W-1:0] xferLen,
  output logic [2*IDX_W-1:0] frameCntOut,
  output logic [2*IDX_W-1:0] sampCntOut,
  output logic [1:0]         leftoverOut
);

  localparam int SAMP_W = IDX_W + 3;
  localparam int CMP_W  = ((SAMP_W > GRANT_W) ? SAMP_W : GRANT_W) + 1;

  logic [ADDR_W-1:0]  frameAddrQ;
  logic [IDX_W-1:0]   indexQ, sizeQ, curQ, reloadQ;
  logic [1:0]         leftQ;
  logic [1:0]         shiftQ;
  logic [CMP_W-1:0]   sampBytesQ;

  // request side
  logic [1:0]         shiftNow;
  logic [GRANT_W-1:0] roundedGrant;
  logic [CMP_W-1:0]   bufLeft, sampBytesNow, firstMin, lenWide;
  logic [ADDR_W-1:0]  addrNow;

  always_comb begin
    shiftNow     = {1'b0, stereo} + {1'b0, wide16};
    roundedGrant = (grantBytes >> shiftNow) << shiftNow;
    bufLeft      = ((CMP_W'(sizeQ) - CMP_W'(indexQ) + CMP_W'(1)) << 2) + CMP_W'(leftQ);
    sampBytesNow = (CMP_W'(curQ) + CMP_W'(1)) << shiftNow;
    firstMin     = (CMP_W'(roundedGrant) < bufLeft) ? CMP_W'(roundedGrant) : bufLeft;
    lenWide      = (firstMin < sampBytesNow) ? firstMin : sampBytesNow;
    addrNow      = frameAddrQ + (ADDR_W'(indexQ) << 2) + ADDR_W'(leftQ);
    canStart     = (sizeQ >= indexQ) && (roundedGrant != '0);
  end

  // completion side
  logic [CMP_W-1:0] movedW, totalW, stepIdx, partCnt;
  logic [IDX_W-1:0] wrapIdx;

  always_comb begin
    movedW    = CMP_W'(doneBytes);
    totalW    = movedW + CMP_W'(leftQ);
    stepIdx   = CMP_W'(indexQ) + (totalW >> 2);
    expiryNow = (movedW == sampBytesQ);
    partCnt   = (sampBytesQ - movedW - CMP_W'(1)) >> shiftQ;
    wrapIdx   = (stepIdx <= CMP_W'(sizeQ)) ? IDX_W'(stepIdx) : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameAddrQ <= '0;
      indexQ     <= '0;
      sizeQ      <= '0;
      curQ       <= '0;
      reloadQ    <= '0;
      leftQ      <= '0;
      shiftQ     <= '0;
      sampBytesQ <= '0;
      xferAddr   <= '0;
      xferLen    <= '0;
    end else begin
      if (strobe.latchReq) begin
        xferAddr   <= addrNow;
        xferLen    <= GRANT_W'(lenWide);
        shiftQ     <= shiftNow;
        sampBytesQ <= sampBytesNow;
      end
      if (strobe.commit) begin
        leftQ <= 2'(totalW);
        if (!loopStop) indexQ <= wrapIdx;
        curQ  <= expiryNow ? reloadQ : IDX_W'(partCnt);
      end
      // register writes take priority over a same-cycle completion
      if (frameAddrWe) frameAddrQ <= frameAddrIn;
      if (frameCntWe) begin
        indexQ <= frameCntIn[2*IDX_W-1:IDX_W];
        sizeQ  <= frameCntIn[IDX_W-1:0];
        leftQ  <= '0;
      end
      if (sampCntWe) begin
        curQ    <= sampCntIn;
        reloadQ <= sampCntIn;
      end
    end
  end

  assign frameCntOut = {indexQ, sizeQ};
  assign sampCntOut  = {curQ, reloadQ};
  assign leftoverOut = leftQ;

  // R4: request length is nonzero and whole samples
  assert_len_aligned_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchReq |=> (xferLen != '0) && (((xferLen >> shiftQ) << shiftQ) == xferLen));

  // R8: in loop mode the index never rests beyond the buffer after a completion
  assert_wrap_in_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && !loopStop && !frameCntWe) |=> (indexQ <= sizeQ));

  // R8: stop mode keeps the index
  assert_stop_keeps_idx_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && loopStop && !frameCntWe) |=> $stable(indexQ));

endmodule

// File: rtl/audio_ring_dma_counter.sv
module audio_ring_dma_counter
  import ringdma_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 16,
  parameter int GRANT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameAddrWe,
  input  logic [ADDR_W-1:0]  frameAddrIn,
  input  logic               frameCntWe,
  input  logic [2*IDX_W-1:0] frameCntIn,
  input  logic               sampCntWe,
  input  logic [IDX_W-1:0]   sampCntIn,
  input  logic               chanEnable,
  input  logic               chanPause,
  input  logic               loopStop,
  input  logic               stereo,
  input  logic               wide16,
  input  logic               intEnable,
  input  logic               irqPending,
  input  logic               grantValid,
  input  logic [GRANT_W-1:0] grantBytes,
  output logic               xferValid,
  output logic [ADDR_W-1:0]  xferAddr,
  output logic [GRANT_W-1:0] xferLen,
  input  logic               doneValid,
  input  logic [GRANT_W-1:0] doneBytes,
  output logic               busy,
  output logic               irqSet,
  output logic               lostIrq,
  output logic [2*IDX_W-1:0] frameCntOut,
  output logic [2*IDX_W-1:0] sampCntOut,
  output logic [1:0]         leftoverOut
);

  pathStrobe_t strobe;
  logic        canStart;
  logic        expiryNow;

  ringdma_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .grantValid (grantValid),
    .chanEnable (chanEnable),
    .chanPause  (chanPause),
    .canStart   (canStart),
    .doneValid  (doneValid),
    .expiryNow  (expiryNow),
    .intEnable  (intEnable),
    .irqPending (irqPending),
    .strobe     (strobe),
    .xferValid  (xferValid),
    .busy       (busy),
    .irqSet     (irqSet),
    .lostIrq    (lostIrq)
  );

  ringdma_path #(
    .ADDR_W  (ADDR_W),
    .IDX_W   (IDX_W),
    .GRANT_W (GRANT_W)
  ) i_path (
    .clk         (clk),
    .rstN        (rstN),
    .frameAddrWe (frameAddrWe),
    .frameAddrIn (frameAddrIn),
    .frameCntWe  (frameCntWe),
    .frameCntIn  (frameCntIn),
    .sampCntWe   (sampCntWe),
    .sampCntIn   (sampCntIn),
    .stereo      (stereo),
    .wide16      (wide16),
    .loopStop    (loopStop),
    .grantBytes  (grantBytes),
    .doneBytes   (doneBytes),
    .strobe      (strobe),
    .canStart    (canStart),
    .expiryNow   (expiryNow),
    .xferAddr    (xferAddr),
    .xferLen     (xferLen),
    .frameCntOut (frameCntOut),
    .sampCntOut  (sampCntOut),
    .leftoverOut (leftoverOut)
  );

endmodule

// File: tb/test_audio_ring_dma_counter.sv
module test_audio_ring_dma_counter;

  localparam logic [31:0] BASE = 32'h1000_0000;

  typedef struct packed {
    logic [1:0]  fmt;      // {wide16, stereo}
    logic        stop;
    logic [15:0] idx;
    logic [15:0] size;
    logic [15:0] samp;
    logic [15:0] grant;
    logic [15:0] moved;
    logic [31:0] expOff;
    logic [15:0] expLen;
    logic [31:0] expFrame;
    logic [31:0] expSamp;
    logic [1:0]  expLeft;
    logic        expIrq;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 1'b0, 16'd0, 16'd7,   16'd9,  16'd16,  16'd10, 32'd0,  16'd10, 32'h0002_0007, 32'h0009_0009, 2'd2, 1'b1},
    '{2'd3, 1'b0, 16'd3, 16'd5,   16'd99, 16'd23,  16'd12, 32'd12, 16'd12, 32'h0000_0005, 32'h0060_0063, 2'd0, 1'b0},
    '{2'd3, 1'b1, 16'd3, 16'd5,   16'd99, 16'd23,  16'd12, 32'd12, 16'd12, 32'h0003_0005, 32'h0060_0063, 2'd0, 1'b0},
    '{2'd1, 1'b0, 16'd0, 16'd100, 16'd3,  16'd100, 16'd6,  32'd0,  16'd8,  32'h0001_0064, 32'h0000_0003, 2'd2, 1'b0},
    '{2'd2, 1'b0, 16'd4, 16'd4,   16'd1,  16'd3,   16'd2,  32'd16, 16'd2,  32'h0004_0004, 32'h0000_0001, 2'd2, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameAddrWe = 1'b0;
  logic [31:0] frameAddrIn = '0;
  logic        frameCntWe = 1'b0;
  logic [31:0] frameCntIn = '0;
  logic        sampCntWe = 1'b0;
  logic [15:0] sampCntIn = '0;
  logic        chanEnable = 1'b1;
  logic        chanPause = 1'b0;
  logic        loopStop = 1'b0;
  logic        stereo = 1'b0;
  logic        wide16 = 1'b0;
  logic        intEnable = 1'b1;
  logic        irqPending = 1'b0;
  logic        grantValid = 1'b0;
  logic [15:0] grantBytes = '0;
  logic        doneValid = 1'b0;
  logic [15:0] doneBytes = '0;
  logic        xferValid, busy, irqSet, lostIrq;
  logic [31:0] xferAddr, frameCntOut, sampCntOut;
  logic [15:0] xferLen;
  logic [1:0]  leftoverOut;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  audio_ring_dma_counter i_audio_ring_dma_counter (
    .clk(clk), .rstN(rstN),
    .frameAddrWe(frameAddrWe), .frameAddrIn(frameAddrIn),
    .frameCntWe(frameCntWe), .frameCntIn(frameCntIn),
    .sampCntWe(sampCntWe), .sampCntIn(sampCntIn),
    .chanEnable(chanEnable), .chanPause(chanPause), .loopStop(loopStop),
    .stereo(stereo), .wide16(wide16), .intEnable(intEnable), .irqPending(irqPending),
    .grantValid(grantValid), .grantBytes(grantBytes),
    .xferValid(xferValid), .xferAddr(xferAddr), .xferLen(xferLen),
    .doneValid(doneValid), .doneBytes(doneBytes),
    .busy(busy), .irqSet(irqSet), .lostIrq(lostIrq),
    .frameCntOut(frameCntOut), .sampCntOut(sampCntOut), .leftoverOut(leftoverOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic setup(input logic [31:0] frame, input logic [15:0] samp);
    @(negedge clk);
    frameAddrWe = 1'b1; frameAddrIn = BASE;
    frameCntWe = 1'b1;  frameCntIn = frame;
    sampCntWe = 1'b1;   sampCntIn = samp;
    @(negedge clk);
    frameAddrWe = 1'b0; frameCntWe = 1'b0; sampCntWe = 1'b0;
  endtask

  // leaves the bench at the falling edge after the grant edge
  task automatic issueGrant(input logic [15:0] bytes);
    @(negedge clk);
    grantValid = 1'b1; grantBytes = bytes;
    @(negedge clk);
    grantValid = 1'b0;
  endtask

  // one edge moves REQ to WAIT, the next applies the completion
  task automatic finishDone(input logic [15:0] bytes);
    @(negedge clk);
    doneValid = 1'b1; doneBytes = bytes;
    @(negedge clk);
    doneValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    chk("R1 xferValid", 32'(xferValid), 32'd0);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 irqSet", 32'(irqSet | lostIrq), 32'd0);
    chk("R1 frameCnt", frameCntOut, 32'd0);
    chk("R1 sampCnt", sampCntOut, 32'd0);
    chk("R1 leftover", 32'(leftoverOut), 32'd0);
    rstN = 1'b1;

    // R2 register loads
    setup(32'h0005_0009, 16'd7);
    chk("R2 frame load", frameCntOut, 32'h0005_0009);
    chk("R2 samp load", sampCntOut, 32'h0007_0007);

    // vector table: R3 R4 R7 R8 R9 R10
    for (int v = 0; v < NVEC; v++) begin
      stereo = VECS[v].fmt[0]; wide16 = VECS[v].fmt[1]; loopStop = VECS[v].stop;
      setup({VECS[v].idx, VECS[v].size}, VECS[v].samp);
      issueGrant(VECS[v].grant);
      chk($sformatf("R3 vec%0d valid", v), 32'(xferValid), 32'd1);
      chk($sformatf("R3 vec%0d addr", v), xferAddr, BASE + VECS[v].expOff);
      chk($sformatf("R4 vec%0d len", v), 32'(xferLen), 32'(VECS[v].expLen));
      finishDone(VECS[v].moved);
      chk($sformatf("R8 R7 vec%0d frame", v), frameCntOut, VECS[v].expFrame);
      chk($sformatf("R9 vec%0d samp", v), sampCntOut, VECS[v].expSamp);
      chk($sformatf("R7 vec%0d leftover", v), 32'(leftoverOut), 32'(VECS[v].expLeft));
      chk($sformatf("R10 vec%0d irq", v), 32'(irqSet), 32'(VECS[v].expIrq));
      chk($sformatf("R12 vec%0d idle", v), 32'(busy), 32'd0);
    end

    // R3 R7 leftover carried into the next address
    stereo = 1'b1; wide16 = 1'b0; loopStop = 1'b0;
    setup(32'h0000_0064, 16'd3);
    issueGrant(16'd100);
    finishDone(16'd6);
    issueGrant(16'd10);
    chk("R3 carry addr", xferAddr, BASE + 32'd6);
    chk("R4 carry len", 32'(xferLen), 32'd2);
    finishDone(16'd2);
    chk("R7 carry frame", frameCntOut, 32'h0002_0064);
    chk("R7 carry leftover", 32'(leftoverOut), 32'd0);
    chk("R9 carry reload", sampCntOut, 32'h0003_0003);
    chk("R10 carry irq", 32'(irqSet), 32'd1);

    // R5 size below index
    stereo = 1'b0; wide16 = 1'b0;
    setup(32'h0005_0004, 16'd9);
    issueGrant(16'd4);
    chk("R5 size<index valid", 32'(xferValid), 32'd0);
    @(negedge clk);
    chk("R5 size<index busy", 32'(busy | xferValid), 32'd0);

    // R5 grant rounds to zero
    stereo = 1'b1; wide16 = 1'b1;
    setup(32'h0000_0007, 16'd9);
    issueGrant(16'd3);
    chk("R5 zero grant valid", 32'(xferValid), 32'd0);
    @(negedge clk);
    chk("R5 zero grant busy", 32'(busy | xferValid), 32'd0);

    // R6 pause and disable
    stereo = 1'b0; wide16 = 1'b0;
    chanPause = 1'b1;
    issueGrant(16'd4);
    chk("R6 paused valid", 32'(xferValid | busy), 32'd0);
    chk("R6 paused frame", frameCntOut, 32'h0000_0007);
    chanPause = 1'b0; chanEnable = 1'b0;
    issueGrant(16'd4);
    chk("R6 disabled valid", 32'(xferValid | busy), 32'd0);
    chk("R6 disabled samp", sampCntOut, 32'h0009_0009);
    chanEnable = 1'b1;

    // R12 grants ignored while waiting
    issueGrant(16'd4);
    chk("R12 first valid", 32'(xferValid), 32'd1);
    @(negedge clk);
    grantValid = 1'b1; grantBytes = 16'd4;
    @(negedge clk);
    grantValid = 1'b0;
    chk("R12 second ignored", 32'(xferValid), 32'd0);
    chk("R12 busy", 32'(busy), 32'd1);
    @(negedge clk);
    doneValid = 1'b1; doneBytes = 16'd4;
    @(negedge clk);
    doneValid = 1'b0;
    chk("R12 frame after", frameCntOut, 32'h0001_0007);
    chk("R12 samp after", sampCntOut, 32'h0005_0009);

    // R10 disabled interrupt still reloads
    intEnable = 1'b0;
    setup(32'h0000_0007, 16'd1);
    issueGrant(16'd2);
    finishDone(16'd2);
    chk("R10 masked irq", 32'(irqSet), 32'd0);
    chk("R9 masked reload", sampCntOut, 32'h0001_0001);

    // R11 lost interrupt
    intEnable = 1'b1; irqPending = 1'b1;
    setup(32'h0000_0007, 16'd1);
    issueGrant(16'd2);
    finishDone(16'd2);
    chk("R11 irqSet", 32'(irqSet), 32'd1);
    chk("R11 lostIrq", 32'(lostIrq), 32'd1);
    @(negedge clk);
    chk("R10 pulse ends", 32'(irqSet | lostIrq), 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule